// File: doc/BRIEF.md
# Radix page table walker

This block resolves a translation miss. A TLB hands it an effective address, a process ID and a flag for the instruction or data side. The walker then reads a chain of 64-bit entries from memory, one at a time. It reads the partition word first, then the process-table entry for the requesting process, then one directory entry per tree level until it reaches a leaf. It returns either a real page number with its page size or a fault code. The shape of the tree is not built into the hardware. The process-table entry gives the size of the address space and the index width of the root level. Each directory entry gives the index width of the level below it. The page size is whatever remains once the last index has been taken.

There are three streams, and each uses valid/ready. A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. A memory read is issued on `mem_req_*`: the walker holds the address steady until `mem_req_ready`, and it consumes `mem_rsp_data` only in a cycle where `mem_rsp_ready` and `mem_rsp_valid` are both high. The outcome stays on `res_*` with `res_valid` high until `res_ready` is seen. Only one walk is in flight at a time, and no intermediate entry is kept between walks.

Entry layout, shared by every table level: bit 63 is valid, bit 62 is leaf, bits 61:56 hold the address-space size in bits (process-table entry only), bits 55:8 hold the next table base (bits 55:12 are the real page on a leaf), and bits 7:0 hold the next-level index width.

Top module: `radix_walker`

## Requirements
- R1: After reset the walker is idle, with `req_ready`=1, `busy`=0 and no read or result valid. A request is accepted only while idle. `busy` stays 1 from the accepting edge until the edge where the result is accepted, and no second request is taken in between.
- R2: The first read is at `ptcr_base`+8. Bits 55:12 of that word, with the low 12 bits zero, form the process-table base. The second read is at that base + 8×PID.
- R3: In the process-table entry, bit 63 is valid, bits 61:56 are the space size S, bits 55:8 are the root base (low 8 bits zero) and bits 7:0 are the root index width N. The first directory read is at root base + 8×EA[S-1:S-N].
- R4: A valid directory entry with bit 62 clear supplies the next base (bits 55:8) and index width (bits 7:0). The walk then reads at base + 8×(the next N effective-address bits below those already used). Trees of 1 up to 10 levels walk until a leaf.
- R5: A valid leaf ends the walk with fault 0. `res_shift` is the page shift left after the last index. `res_rpn` is leaf bits 55:12, except that page-number bits below `res_shift`-12 are taken from the effective address.
- R6: A clear valid bit in the process-table entry or in any directory entry gives fault code 1.
- R7: Fault code 2 is given for any of these: a space size outside 31..62, an index width outside 5..16, an index that would push the page shift below 12, or a walk deeper than 10 levels.
- R8: A nonzero effective-address bit at or above S gives fault code 3, and no directory read is made.
- R9: `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready`. Exactly the reads of R2–R4 are issued, in order, and nothing more.
- R10: While `res_valid`=1 and `res_ready`=0, every result field stays unchanged.
- R11: Each miss walks from the root again. Repeating a request repeats every read, and it returns a changed leaf's new contents.
- R12: A faulting result has `res_rpn`=0 and `res_shift`=0. Every result echoes EA bits 63:12 on `res_epn` and the request's side flag on `res_iside`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptcr_base | input | RA_W | Partition table base address |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Walker can take a request |
| req_ea | input | EA_W | Missed effective address |
| req_pid | input | PID_W | Process ID |
| req_iside | input | 1 | 1 = instruction side, 0 = data side |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | RA_W | Read address (8-byte aligned) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker consumes read data |
| mem_rsp_data | input | 64 | Read data |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Requester takes the result |
| res_iside | output | 1 | Side flag of the walk |
| res_fault | output | 2 | 0 ok, 1 invalid entry, 2 bad size, 3 address out of range |
| res_shift | output | 6 | log2 of page size (0 on fault) |
| res_rpn | output | RA_W-12 | Real page number (0 on fault) |
| res_epn | output | EA_W-12 | Effective page number of the walk |
| busy | output | 1 | Walk in progress |

## Verification
Some properties are checked on every cycle. Both outgoing streams must hold steady under back-pressure. Busy must rise on acceptance and fall on result handoff. The three handshake roles are mutually exclusive. Every successful result must carry the effective-address bits below its page shift and a page shift inside 12..62. Other behaviour depends on the memory contents and can only be shown by the bench scenarios: the exact address sequence of the reads, the index slicing for different tree shapes (1, 2, 4 and 10 levels), large-page merging, the fault priority, and the absence of caching across repeated and rewritten walks.

// File: rtl/radix_walker_pkg.sv
package radix_walker_pkg;

  localparam int ENT_VALID_BIT = 63;
  localparam int ENT_LEAF_BIT  = 62;
  localparam int ENT_SPACE_HI  = 61;
  localparam int ENT_SPACE_LO  = 56;
  localparam int ENT_BASE_LO   = 8;
  localparam int PAGE_MIN_SH   = 12;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_SIZE    = 2'd2,
    FLT_RANGE   = 2'd3
  } walk_fault_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2,
    S_RESP = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    PH_PART = 2'd0,
    PH_PROC = 2'd1,
    PH_DIR  = 2'd2
  } walk_phase_e;

endpackage

// File: rtl/rw_level_step.sv
// One tree level: checks the index width, slices the index out of the
// effective address and forms the address of the next entry.
module rw_level_step #(
  parameter int EA_W    = 64,
  parameter int RA_W    = 56,
  parameter int NLS_MIN = 5,
  parameter int NLS_MAX = 16,
  parameter int SH_MIN  = 12
) (
  input  logic [EA_W-1:0] ea,
  input  logic [6:0]      shift_in,
  input  logic [RA_W-9:0] tbl_base,
  input  logic [7:0]      nls,
  output logic            ok,
  output logic [6:0]      shift_out,
  output logic [RA_W-1:0] ent_addr
);
  localparam int IDX_W = 16;

  logic            nls_ok;
  logic            room_ok;
  logic [IDX_W-1:0] idx_mask;
  logic [IDX_W-1:0] idx;
  logic [RA_W-1:0]  base_full;

  always_comb begin
    nls_ok    = (nls >= 8'(NLS_MIN)) && (nls <= 8'(NLS_MAX));
    room_ok   = {2'b00, shift_in} >= ({1'b0, nls} + 9'(SH_MIN));
    shift_out = shift_in - {2'b00, nls[4:0]};
    idx_mask  = (IDX_W'(1) << nls[4:0]) - IDX_W'(1);
    idx       = IDX_W'(ea >> shift_out) & idx_mask;
    base_full = {tbl_base, 8'h00};
    ent_addr  = base_full + RA_W'({idx, 3'b000});
    ok        = nls_ok && room_ok;
  end

endmodule

// File: rtl/rw_page_merge.sv
// Builds the returned page number of a leaf: page-number bits below the
// page shift come from the effective address.
module rw_page_merge #(
  parameter int PN_W = 44
) (
  input  logic [PN_W-1:0] leaf_pn,
  input  logic [PN_W-1:0] ea_pn,
  input  logic [6:0]      page_sh,
  output logic [PN_W-1:0] rpn
);
  logic [6:0]      sub_sh;
  logic [PN_W-1:0] low_mask;

  always_comb begin
    sub_sh   = page_sh - 7'd12;
    low_mask = (PN_W'(1) << sub_sh) - PN_W'(1);
    rpn      = (leaf_pn & ~low_mask) | (ea_pn & low_mask);
  end

endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import radix_walker_pkg::*;
#(
  parameter int EA_W       = 64,
  parameter int RA_W       = 56,
  parameter int PID_W      = 20,
  parameter int MAX_LEVELS = 10,
  parameter int NLS_MIN    = 5,
  parameter int NLS_MAX    = 16,
  parameter int SPACE_MIN  = 31,
  parameter int SPACE_MAX  = 62
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   ptcr_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [EA_W-1:0]   req_ea,
  input  logic [PID_W-1:0]  req_pid,
  input  logic              req_iside,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [RA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [63:0]       mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_iside,
  output logic [1:0]        res_fault,
  output logic [5:0]        res_shift,
  output logic [RA_W-13:0]  res_rpn,
  output logic [EA_W-13:0]  res_epn,
  output logic              busy
);
  localparam int PN_W  = RA_W - PAGE_MIN_SH;
  localparam int LVL_W = $clog2(MAX_LEVELS + 1);

  walk_state_e state_q;
  walk_phase_e phase_q;
  walk_fault_e fault_q;
  walk_fault_e fault_c;
  logic [EA_W-1:0]  ea_q;
  logic [PID_W-1:0] pid_q;
  logic             iside_q;
  logic [RA_W-1:0]  addr_q;
  logic [6:0]       shift_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PN_W-1:0]  rpn_q;
  logic [5:0]       rshift_q;

  // fields of the entry on the read-data bus
  logic        ent_v;
  logic        ent_leaf;
  logic [5:0]  ent_space;
  logic        space_ok;
  logic        range_bad;
  logic [RA_W-1:0] part_next;

  logic        go_c;
  logic        leaf_c;
  logic [6:0]  step_shin;
  logic        step_ok;
  logic [6:0]  step_shift;
  logic [RA_W-1:0] step_addr;
  logic [PN_W-1:0] merge_rpn;

  assign ent_v     = mem_rsp_data[ENT_VALID_BIT];
  assign ent_leaf  = mem_rsp_data[ENT_LEAF_BIT];
  assign ent_space = mem_rsp_data[ENT_SPACE_HI:ENT_SPACE_LO];
  assign space_ok  = (ent_space >= 6'(SPACE_MIN)) && (ent_space <= 6'(SPACE_MAX));
  assign range_bad = (ea_q >> ent_space) != '0;
  assign part_next = {mem_rsp_data[RA_W-1:PAGE_MIN_SH], 12'h000}
                   + (RA_W'(pid_q) << 3);
  assign step_shin = (phase_q == PH_PROC) ? {1'b0, ent_space} : shift_q;

  rw_level_step #(
    .EA_W(EA_W), .RA_W(RA_W), .NLS_MIN(NLS_MIN), .NLS_MAX(NLS_MAX), .SH_MIN(PAGE_MIN_SH)
  ) u_step (
    .ea        (ea_q),
    .shift_in  (step_shin),
    .tbl_base  (mem_rsp_data[RA_W-1:ENT_BASE_LO]),
    .nls       (mem_rsp_data[7:0]),
    .ok        (step_ok),
    .shift_out (step_shift),
    .ent_addr  (step_addr)
  );

  rw_page_merge #(.PN_W(PN_W)) u_merge (
    .leaf_pn (mem_rsp_data[RA_W-1:PAGE_MIN_SH]),
    .ea_pn   (ea_q[RA_W-1:PAGE_MIN_SH]),
    .page_sh (shift_q),
    .rpn     (merge_rpn)
  );

  // Decision on the entry just returned: fault, leaf, or descend.
  always_comb begin
    fault_c = FLT_NONE;
    go_c    = 1'b0;
    leaf_c  = 1'b0;
    if (phase_q == PH_PROC) begin
      if (!ent_v)          fault_c = FLT_INVALID;
      else if (!space_ok)  fault_c = FLT_SIZE;
      else if (range_bad)  fault_c = FLT_RANGE;
      else if (!step_ok)   fault_c = FLT_SIZE;
      else                 go_c    = 1'b1;
    end else begin
      if (!ent_v)                            fault_c = FLT_INVALID;
      else if (ent_leaf)                     leaf_c  = 1'b1;
      else if (lvl_q == LVL_W'(MAX_LEVELS))  fault_c = FLT_SIZE;
      else if (!step_ok)                     fault_c = FLT_SIZE;
      else                                   go_c    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      phase_q  <= PH_PART;
      fault_q  <= FLT_NONE;
      ea_q     <= '0;
      pid_q    <= '0;
      iside_q  <= 1'b0;
      addr_q   <= '0;
      shift_q  <= '0;
      lvl_q    <= '0;
      rpn_q    <= '0;
      rshift_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          ea_q    <= req_ea;
          pid_q   <= req_pid;
          iside_q <= req_iside;
          addr_q  <= ptcr_base + RA_W'(8);
          phase_q <= PH_PART;
          lvl_q   <= '0;
          state_q <= S_REQ;
        end
        S_REQ: if (mem_req_ready) state_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (phase_q == PH_PART) begin
            addr_q  <= part_next;
            phase_q <= PH_PROC;
            state_q <= S_REQ;
          end else if (go_c) begin
            addr_q  <= step_addr;
            shift_q <= step_shift;
            lvl_q   <= lvl_q + LVL_W'(1);
            phase_q <= PH_DIR;
            state_q <= S_REQ;
          end else begin
            fault_q  <= fault_c;
            rpn_q    <= leaf_c ? merge_rpn : '0;
            rshift_q <= leaf_c ? shift_q[5:0] : '0;
            state_q  <= S_RESP;
          end
        end
        S_RESP: if (res_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign busy          = (state_q != S_IDLE);
  assign mem_req_valid = (state_q == S_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_rsp_ready = (state_q == S_WAIT);
  assign res_valid     = (state_q == S_RESP);
  assign res_fault     = fault_q;
  assign res_rpn       = rpn_q;
  assign res_shift     = rshift_q;
  assign res_epn       = ea_q[EA_W-1:PAGE_MIN_SH];
  assign res_iside     = iside_q;

  // checker-side mask of page-offset bits within the page number
  logic [PN_W-1:0] chk_low;
  assign chk_low = (PN_W'(1) << (7'(res_shift) - 7'd12)) - PN_W'(1);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid
      && $stable({res_fault, res_rpn, res_shift, res_epn, res_iside}));

  // R1
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready);

  // R1
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> !busy && req_ready);

  // R1
  one_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_req_valid, mem_rsp_ready, res_valid}));

  // R5
  leaf_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 2'd0 |-> res_shift >= 6'd12 && res_shift <= 6'(SPACE_MAX));

  // R5
  offset_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 2'd0 |-> ((res_rpn ^ res_epn[PN_W-1:0]) & chk_low) == '0);

  // R12
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault != 2'd0 |-> res_rpn == '0 && res_shift == '0);

endmodule

// File: tb/radix_walker_tb.sv
module radix_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;
  localparam logic [63:0] PTCR = 64'h0000_0000_0001_0000;
  localparam logic [63:0] PRTB = 64'h0000_0000_0002_0000;
  localparam logic [63:0] BASE_M = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [63:0] PG_M   = 64'h00FF_FFFF_FFFF_F000;

  typedef struct packed {
    logic [1:0]  fault;
    logic [43:0] rpn;
    logic [5:0]  shift;
    logic [51:0] epn;
    logic        iside;
  } res_t;

  typedef struct {
    logic [63:0] ea;
    int          pid;
    bit          iside;
  } rq_t;

  logic clk = 0;
  logic rst_n = 0;
  logic [55:0] ptcr_base;
  logic req_valid = 0, req_ready, req_iside = 0;
  logic [63:0] req_ea = '0;
  logic [19:0] req_pid = '0;
  logic mem_req_valid, mem_req_ready = 0;
  logic [55:0] mem_req_addr;
  logic mem_rsp_valid = 0, mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic res_valid, res_ready = 0, res_iside;
  logic [1:0] res_fault;
  logic [5:0] res_shift;
  logic [43:0] res_rpn;
  logic [51:0] res_epn;
  logic busy;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign ptcr_base = PTCR[55:0];

  radix_walker u_dut (
    .clk(clk), .rst_n(rst_n), .ptcr_base(ptcr_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_pid(req_pid), .req_iside(req_iside),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_iside(res_iside),
    .res_fault(res_fault), .res_shift(res_shift), .res_rpn(res_rpn),
    .res_epn(res_epn), .busy(busy)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, n_done = 0;
  bit timed_out = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] roots [int];
  logic [63:0] alloc_ptr = 64'h0010_0000;
  rq_t  req_q [$];
  logic [63:0] exp_addr [$];
  string exp_tag [$];
  res_t exp_res [$];
  bit   m_busy = 0;
  bit   slot_full = 0;
  int   slot_wait = 0;
  logic [63:0] slot_data = '0;
  bit   prev_mreq = 0;
  logic [55:0] prev_addr = '0;
  bit   prev_res = 0;
  res_t prev_res_v;

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] alloc(int n);
    logic [63:0] r = alloc_ptr;
    alloc_ptr = alloc_ptr + (((64'd8 << n) + 64'd255) & ~64'd255);
    return r;
  endfunction

  function automatic logic [63:0] mk_dir(logic [63:0] b, int n);
    return (64'd1 << 63) | (b & BASE_M) | 64'(n & 8'hFF);
  endfunction

  function automatic logic [63:0] mk_proc(int sp, logic [63:0] b, int n);
    return mk_dir(b, n) | (64'(sp & 6'h3F) << 56);
  endfunction

  // Reference walk: expected read sequence and result from the requirements.
  function automatic void model_walk(logic [63:0] ea, int pid, bit iside);
    res_t r;
    logic [63:0] a, e, base, idx, m;
    int space, shift, nls, lvl;
    bit fin;
    r = '0; r.epn = ea[63:12]; r.iside = iside;
    a = PTCR + 64'd8; exp_addr.push_back(a); exp_tag.push_back("R2 partition read");
    e = rd(a);
    a = (e & PG_M) + 64'(pid) * 64'd8;
    exp_addr.push_back(a); exp_tag.push_back("R2 process read");
    e = rd(a);
    fin = 0;
    if (!e[63]) begin r.fault = 2'd1; fin = 1; end
    else begin
      space = int'(e[61:56]);
      if (space < 31 || space > 62) begin r.fault = 2'd2; fin = 1; end
      else if ((ea >> space) != 0) begin r.fault = 2'd3; fin = 1; end
    end
    shift = space; lvl = 0;
    while (!fin) begin
      nls = int'(e[7:0]); base = e & BASE_M;
      if (nls < 5 || nls > 16 || shift - nls < 12 || lvl == 10) begin
        r.fault = 2'd2; fin = 1;
      end else begin
        shift = shift - nls; lvl++;
        idx = (ea >> shift) & ((64'd1 << nls) - 64'd1);
        a = base + idx * 64'd8;
        exp_addr.push_back(a);
        exp_tag.push_back(lvl == 1 ? "R3 root read" : "R4 level read");
        e = rd(a);
        if (!e[63]) begin r.fault = 2'd1; fin = 1; end
        else if (e[62]) begin
          m = (64'd1 << (shift - 12)) - 64'd1;
          r.rpn = 44'((((e & PG_M) >> 12) & ~m) | ((ea >> 12) & m));
          r.shift = 6'(shift);
          fin = 1;
        end
      end
    end
    exp_res.push_back(r);
  endfunction

  // Writes the entries along the path of ea; tail_n != 0 makes the last
  // entry a directory with that index width instead of a leaf.
  task automatic build(int pid, int space, int nl[10], int cnt,
                       logic [63:0] ea, logic [63:0] pa, int tail_n);
    logic [63:0] base, a, nb, idx;
    int shift;
    if (!roots.exists(pid)) roots[pid] = alloc(nl[0]);
    base = roots[pid];
    mem[PRTB + 64'(pid) * 8] = mk_proc(space, base, nl[0]);
    shift = space;
    for (int i = 0; i < cnt; i++) begin
      shift = shift - nl[i];
      idx = (ea >> shift) & ((64'd1 << nl[i]) - 64'd1);
      a = base + idx * 8;
      if (i == cnt - 1) begin
        if (tail_n == 0) mem[a] = (64'd3 << 62) | (pa & PG_M);
        else begin nb = alloc(tail_n & 15); mem[a] = mk_dir(nb, tail_n); end
      end else if (mem.exists(a) && mem[a][63] && !mem[a][62]) begin
        base = mem[a] & BASE_M;
      end else begin
        nb = alloc(nl[i+1]); mem[a] = mk_dir(nb, nl[i+1]); base = nb;
      end
    end
  endtask

  task automatic tick();
    res_t cur;
    cyc++;
    if (cyc > WD_LIMIT) timed_out = 1;
    cur = '{res_fault, res_rpn, res_shift, res_epn, res_iside};
    // per-clock comparison with the model's busy state
    chk(busy == m_busy && req_ready == !m_busy, "R1 busy/ready per clock",
        {busy, req_ready}, {m_busy, !m_busy});
    if (prev_mreq) chk(mem_req_valid && mem_req_addr == prev_addr, "R9 read held",
                       mem_req_addr, prev_addr);
    if (prev_res) chk(res_valid && cur == prev_res_v, "R10 result held", cur, prev_res_v);
    // request stream
    if (req_q.size() > 0) begin
      req_valid = 1; req_ea = req_q[0].ea;
      req_pid = 20'(req_q[0].pid); req_iside = req_q[0].iside;
    end else req_valid = 0;
    if (req_valid && req_ready) begin
      model_walk(req_ea, int'(req_pid), req_iside);
      m_busy = 1;
      void'(req_q.pop_front());
    end
    // memory read port
    mem_req_ready = (cyc % 3) != 0;
    if (mem_req_valid && mem_req_ready) begin
      if (exp_addr.size() == 0)
        chk(0, "R9 unexpected read", mem_req_addr, 0);
      else begin
        chk({8'h0, mem_req_addr} == exp_addr[0], exp_tag[0], mem_req_addr, exp_addr[0]);
        void'(exp_addr.pop_front()); void'(exp_tag.pop_front());
      end
      slot_full = 1; slot_data = rd({8'h0, mem_req_addr}); slot_wait = cyc % 2;
    end else if (slot_full && slot_wait > 0) slot_wait--;
    mem_rsp_valid = slot_full && slot_wait == 0;
    mem_rsp_data  = mem_rsp_valid ? slot_data : 64'h0;
    if (mem_rsp_valid && mem_rsp_ready) slot_full = 0;
    // result port
    res_ready = (cyc % 4) != 1;
    if (res_valid && res_ready) begin
      chk(exp_addr.size() == 0, "R9 read count", exp_addr.size(), 0);
      if (exp_res.size() == 0) chk(0, "R1 unexpected result", cur, 0);
      else begin
        chk(cur == exp_res[0], "R5/R6/R7/R8/R12 result", cur, exp_res[0]);
        void'(exp_res.pop_front());
      end
      m_busy = 0; n_done++;
    end
    prev_mreq = mem_req_valid && !mem_req_ready; prev_addr = mem_req_addr;
    prev_res = res_valid && !res_ready; prev_res_v = cur;
  endtask

  always @(negedge clk) if (rst_n) tick();

  task automatic send(logic [63:0] ea, int pid, bit iside);
    rq_t q; q.ea = ea; q.pid = pid; q.iside = iside;
    req_q.push_back(q);
  endtask

  task automatic wait_all(int target);
    while (n_done < target && !timed_out) @(negedge clk);
  endtask

  int total = 0;

  initial begin
    mem[PTCR + 64'd8] = PRTB | 64'h0000_0000_0000_0ABC;
    // R3 four-level 4 KiB tree
    build(1, 52, '{13,9,9,9,0,0,0,0,0,0}, 4, 64'h000A_BCDE_F123_4567, 64'h0012_3456_7000, 0);
    // R5 64 KiB pages, leaf low bits replaced by ea bits
    build(2, 52, '{13,9,9,5,0,0,0,0,0,0}, 4, 64'h0003_1415_9265_3589, 64'h0000_00AB_CDEF_7000, 0);
    // R5 two-level tree, 2 MiB leaf
    build(3, 40, '{10,9,0,0,0,0,0,0,0,0}, 2, 64'h0000_00C3_5A7B_1234, 64'h0000_0040_0000_0000, 0);
    // R4 single-level tree, widest index
    build(4, 31, '{16,0,0,0,0,0,0,0,0,0}, 1, 64'h0000_0000_7FFF_9ABC, 64'h0000_0001_2340_0000, 0);
    // R4 ten-level tree
    build(5, 62, '{5,5,5,5,5,5,5,5,5,5}, 10, 64'h2AAA_5555_0F0F_3C3C, 64'h0000_BEEF_0000_1000, 0);
    // R7 index width 4 at root, space 30, space 63
    mem[PRTB + 64'd8*8]  = mk_proc(40, 64'h0080_0000, 4);
    mem[PRTB + 64'd9*8]  = mk_proc(30, 64'h0080_0000, 9);
    mem[PRTB + 64'd12*8] = mk_proc(63, 64'h0080_0000, 9);
    // R7 fifth level would drop below 4 KiB; index width 17 below root
    build(10, 52, '{13,9,9,9,0,0,0,0,0,0}, 4, 64'h000F_0000_1234_5000, 64'h0, 9);
    build(11, 52, '{13,0,0,0,0,0,0,0,0,0}, 1, 64'h0000_1111_2222_3000, 64'h0, 17);

    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !busy && !mem_req_valid && !res_valid && !mem_rsp_ready,
        "R1 reset state", {req_ready, busy, mem_req_valid, res_valid}, 4'b1000);

    send(64'h000A_BCDE_F123_4567, 1, 0); total++; wait_all(total);   // R3
    send(64'h0003_1415_9265_3589, 2, 1); total++; wait_all(total);   // R5
    send(64'h0000_00C3_5A7B_1234, 3, 0); total++; wait_all(total);   // R5
    send(64'h0000_0000_7FFF_9ABC, 4, 1); total++; wait_all(total);   // R4
    send(64'h2AAA_5555_0F0F_3C3C, 5, 0); total++; wait_all(total);   // R4
    send(64'h0000_0000_0000_0000, 6, 1); total++; wait_all(total);   // R6 process entry
    send(64'h0001_0000_0000_0000, 1, 0); total++; wait_all(total);   // R6 directory entry
    send(64'h0000_0100_0000_0000, 4, 1); total++; wait_all(total);   // R8
    send(64'h0000_0000_1000_0000, 8, 0); total++; wait_all(total);   // R7
    send(64'h0000_0000_1000_0000, 9, 0); total++; wait_all(total);   // R7
    send(64'h0000_0000_1000_0000, 12, 0); total++; wait_all(total);  // R7
    send(64'h000F_0000_1234_5000, 10, 1); total++; wait_all(total);  // R7
    send(64'h0000_1111_2222_3000, 11, 1); total++; wait_all(total);  // R7
    // R1 back-to-back requests held while busy
    send(64'h0003_1415_9265_3589, 2, 0);
    send(64'h0000_00C3_5A7B_1234, 3, 1);
    send(64'h0000_0000_7FFF_9ABC, 4, 0); total += 3; wait_all(total);
    // R11 repeat, then rewrite the leaf and walk again
    send(64'h000A_BCDE_F123_4567, 1, 1); total++; wait_all(total);
    build(1, 52, '{13,9,9,9,0,0,0,0,0,0}, 4, 64'h000A_BCDE_F123_4567, 64'h0077_0000_1000, 0);
    send(64'h000A_BCDE_F123_4567, 1, 0); total++; wait_all(total);
    repeat (3) @(negedge clk);
    // R11 no stray reads or results remain
    chk(exp_addr.size() == 0 && exp_res.size() == 0 && !busy, "R11 idle after walks",
        {exp_addr.size(), exp_res.size()}, 0);
    if (timed_out) chk(0, "watchdog expired", cyc, WD_LIMIT);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule